// File: doc/BRIEF.md
# Loadable DMA Transfer Length Counter

This block keeps the byte count for a DMA transfer. The host writes the count one byte at a time into three staging registers: low, middle and high. A separate readable count is the working copy. It changes only when the host issues a command that carries the DMA flag. That command copies the staged bytes into the working copy. A command without the flag selects programmed I/O and leaves the working copy as it is.

When a transfer starts, the block works out how many bytes will move:
- A working count of zero stands for 65536.
- The result is then capped by the data the target has pending.
- In command phase the cap is a fixed 32 bytes.

The DMA engine then hands bytes across a valid/ready handshake. Each accepted byte lowers the remaining length and the readable count. When the remaining length reaches zero, the block does four things in the same edge: it drops `busy`, sets the terminal-count flag, clears the readable count, and pulses a one-cycle bus-service completion.

Back-pressure rule: `beat_ready` is high exactly while a transfer is in progress. A byte counts only in a cycle where `beat_valid` and `beat_ready` are both high. The engine may hold `beat_valid` high at any time. While the block is idle, those bytes are not taken.

Top module: `dma_xfer_counter`

## Requirements
- R1: A host byte write with `wr_sel` 0, 1 or 2 loads the low, middle or high staging byte, counted from bit 0, bit 8 and bit 16 of the count. A write alone never changes `rd_count`.
- R2: A host write to any of the three count bytes clears `tc` on the next edge, unless a completion happens in the same cycle.
- R3: `cmd_valid` with `cmd_dma`=1 loads `rd_count` from the staged bytes on the next edge. With `cmd_dma`=0, `rd_count` is left unchanged.
- R4: An accepted start sets `xfer_len` to the smaller of the effective count and the cap. The effective count is `rd_count`, or 65536 when `rd_count` is zero. The cap is 32 when `cmd_phase`=1 and `pending` otherwise.
- R5: A start is accepted only while `busy`=0. An accepted start clears `tc` and raises `busy` when the length is nonzero. A start while busy has no effect.
- R6: `beat_ready` equals `busy`. Each accepted beat lowers the remaining length by one and lowers `rd_count` by one. `rd_count` stops at zero and does not wrap.
- R7: When the beat that brings the remaining length to zero is accepted, the next edge does all of the following: `busy` falls, `tc` is set, `rd_count` becomes 0, and `done` is high for exactly one cycle.
- R8: An accepted start whose length is zero completes at once, with the same results as R7, and `busy` stays low.
- R9: After reset, `rd_count` is {CHIP_ID, 16'h0000}, `tc`, `busy` and `done` are 0, `xfer_len` is 0, and all staging bytes are 0.
- R10: A completion wins over a same-cycle byte write, so `tc` ends at 1. A completion also wins over a same-cycle DMA-flagged command, so `rd_count` ends at 0.
- R11: A host write with `wr_sel`=3 changes no staging byte and does not clear `tc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_sel | input | 2 | Byte select: 0 low, 1 middle, 2 high, 3 none |
| wr_data | input | 8 | Host write data |
| cmd_valid | input | 1 | Host command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| start | input | 1 | Begin a transfer |
| pending | input | 17 | Bytes the target has pending |
| cmd_phase | input | 1 | Transfer is in command phase (cap of 32) |
| beat_valid | input | 1 | DMA engine offers one byte |
| beat_ready | output | 1 | Block accepts a byte |
| busy | output | 1 | Transfer in progress |
| xfer_len | output | 17 | Length chosen at the last accepted start |
| rd_count | output | 24 | Readable working count |
| tc | output | 1 | Terminal-count flag |
| done | output | 1 | One-cycle bus-service completion pulse |

## Verification
The interesting overlap is a completion landing in the same cycle as a host action that also touches the same state. A byte write would clear terminal count. A DMA-flagged command would reload the readable count.

Directed sequences arrange the final accepted beat so that it coincides with each of those host actions. The bench then checks that `tc` stays 1 and `rd_count` stays 0. The random phase issues writes, commands, starts and beats freely, so these overlaps and the start-versus-reload overlap recur. Each cycle is judged against a bench model that applies completion first, then reload, then decrement.

// File: rtl/dmacnt_pkg.sv
package dmacnt_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } byte_sel_e;
endpackage

// File: rtl/dmacnt_bytebank.sv
module dmacnt_bytebank #(
  parameter int NBYTES = 3,
  parameter int BW     = 8,
  localparam int WW    = NBYTES * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [BW-1:0] wr_data,
  output logic [WW-1:0] wr_word,
  output logic          wr_hit
);
  assign wr_hit = wr_en && (int'(wr_sel) < NBYTES);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [BW-1:0] stage_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else if (wr_en && int'(wr_sel) == g) begin
        stage_q <= wr_data;
      end
    end

    assign wr_word[g*BW +: BW] = stage_q;
  end
endmodule

// File: rtl/dmacnt_lencalc.sv
module dmacnt_lencalc #(
  parameter int CNT_W    = 24,
  parameter int LEN_W    = 17,
  parameter int ZERO_LEN = 65536,
  parameter int CMD_CAP  = 32,
  localparam int EFF_W   = CNT_W + 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic [LEN_W-1:0] pending,
  input  logic             cmd_phase,
  output logic [LEN_W-1:0] len
);
  logic [EFF_W-1:0] eff;
  logic [EFF_W-1:0] cap;
  logic [EFF_W-1:0] pick;

  always_comb begin
    eff  = (count == '0) ? EFF_W'(ZERO_LEN) : {1'b0, count};
    cap  = cmd_phase ? EFF_W'(CMD_CAP) : EFF_W'(pending);
    pick = (eff < cap) ? eff : cap;
    len  = pick[LEN_W-1:0];
  end
endmodule

// File: rtl/dmacnt_down.sv
module dmacnt_down #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] load_len,
  input  logic             beat_valid,
  output logic             beat_ready,
  output logic             busy,
  output logic             start_acc,
  output logic             beat_fire,
  output logic             fin
);
  logic [LEN_W-1:0] remaining;

  assign beat_ready = busy;
  assign start_acc  = start && !busy;
  assign beat_fire  = busy && beat_valid;
  assign fin        = (start_acc && load_len == '0) ||
                      (beat_fire && remaining == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      busy      <= 1'b0;
    end else if (start_acc) begin
      remaining <= load_len;
      busy      <= (load_len != '0);
    end else if (beat_fire) begin
      remaining <= remaining - LEN_W'(1);
      if (remaining == LEN_W'(1)) busy <= 1'b0;
    end
  end

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && remaining > LEN_W'(1)) |=>
      (busy && remaining == $past(remaining) - LEN_W'(1)));

  a_r7_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && remaining == LEN_W'(1)) |=> !busy);

  a_r5_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !beat_valid) |=> (busy && $stable(remaining)));
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int          NBYTES   = 3,
  parameter int          BW       = 8,
  parameter int          LEN_W    = 17,
  parameter int          ZERO_LEN = 65536,
  parameter int          CMD_CAP  = 32,
  parameter logic [7:0]  CHIP_ID  = 8'hA2,
  localparam int         CNT_W    = NBYTES * BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [BW-1:0]    wr_data,
  input  logic             cmd_valid,
  input  logic             cmd_dma,
  input  logic             start,
  input  logic [LEN_W-1:0] pending,
  input  logic             cmd_phase,
  input  logic             beat_valid,
  output logic             beat_ready,
  output logic             busy,
  output logic [LEN_W-1:0] xfer_len,
  output logic [CNT_W-1:0] rd_count,
  output logic             tc,
  output logic             done
);
  import dmacnt_pkg::*;

  localparam logic [CNT_W-1:0] RST_COUNT = {CHIP_ID, (CNT_W-8)'(0)};

  logic [CNT_W-1:0] wr_word;
  logic             wr_hit;
  logic [LEN_W-1:0] calc_len;
  logic             start_acc;
  logic             beat_fire;
  logic             fin;

  dmacnt_bytebank #(.NBYTES(NBYTES), .BW(BW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_word(wr_word), .wr_hit(wr_hit)
  );

  dmacnt_lencalc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .ZERO_LEN(ZERO_LEN),
                   .CMD_CAP(CMD_CAP)) u_len (
    .count(rd_count), .pending(pending), .cmd_phase(cmd_phase), .len(calc_len)
  );

  dmacnt_down #(.LEN_W(LEN_W)) u_down (
    .clk(clk), .rst_n(rst_n), .start(start), .load_len(calc_len),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .busy(busy),
    .start_acc(start_acc), .beat_fire(beat_fire), .fin(fin)
  );

  // Priority: completion zeroes, then reload, then per-byte decrement.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_count <= RST_COUNT;
      tc       <= 1'b0;
      done     <= 1'b0;
      xfer_len <= '0;
    end else begin
      done <= fin;
      if (start_acc) xfer_len <= calc_len;

      if (fin)                        rd_count <= '0;
      else if (cmd_valid && cmd_dma)  rd_count <= wr_word;
      else if (beat_fire && rd_count != '0) rd_count <= rd_count - CNT_W'(1);

      if (fin)                        tc <= 1'b1;
      else if (wr_hit || start_acc)   tc <= 1'b0;
    end
  end

  a_r7_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tc && rd_count == '0 && !busy));

  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != SEL_NONE && !fin) |=> !tc);

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_dma && !fin) |=> (rd_count == $past(wr_word)));

  a_r4_cmd_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && cmd_phase) |=> (xfer_len <= LEN_W'(CMD_CAP)));

  a_r10_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (tc && done));
endmodule

// File: tb/dma_xfer_counter_bench.sv
module dma_xfer_counter_bench;
  localparam logic [7:0] CHIP_ID = 8'hA2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, cmd_valid = 0, cmd_dma = 0, start = 0;
  logic        cmd_phase = 0, beat_valid = 0;
  logic [1:0]  wr_sel = 0;
  logic [7:0]  wr_data = 0;
  logic [16:0] pending = 0;
  logic        beat_ready, busy, tc, done;
  logic [16:0] xfer_len;
  logic [23:0] rd_count;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dma_xfer_counter #(.CHIP_ID(CHIP_ID)) u_dma_xfer_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd_dma(cmd_dma),
    .start(start), .pending(pending), .cmd_phase(cmd_phase),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .busy(busy),
    .xfer_len(xfer_len), .rd_count(rd_count), .tc(tc), .done(done)
  );

  // Bench model state, built from the requirements.
  logic [7:0]  m_w [3];
  logic [23:0] m_rd;
  logic        m_tc, m_busy, m_done;
  logic [16:0] m_rem, m_len;

  function automatic logic [16:0] f_len(logic [23:0] c, logic [16:0] p,
                                         logic cph);
    logic [24:0] eff;
    logic [24:0] cap;
    eff = (c == 0) ? 25'd65536 : {1'b0, c};
    cap = cph ? 25'd32 : {8'd0, p};
    return (eff < cap) ? eff[16:0] : cap[16:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_w[i] = 8'h00;
      m_rd = {CHIP_ID, 16'h0000}; m_tc = 0; m_busy = 0; m_done = 0;
      m_rem = 0; m_len = 0;
    end else begin
      logic        hit, sacc, fire, fin;
      logic [16:0] l;
      logic [23:0] staged;
      hit    = wr_en && wr_sel != 2'd3;
      sacc   = start && !m_busy;
      l      = f_len(m_rd, pending, cmd_phase);
      fire   = m_busy && beat_valid;
      fin    = (sacc && l == 0) || (fire && m_rem == 1);
      staged = {m_w[2], m_w[1], m_w[0]};
      if (hit) m_w[wr_sel] = wr_data;
      if (sacc) begin
        m_len = l; m_rem = l; m_busy = (l != 0);
      end else if (fire) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) m_busy = 0;
      end
      if (fin) m_rd = 0;
      else if (cmd_valid && cmd_dma) m_rd = staged;
      else if (fire && m_rd != 0) m_rd = m_rd - 1;
      if (fin) m_tc = 1;
      else if (hit || sacc) m_tc = 0;
      m_done = fin;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lockstep();
    chk(32'(rd_count), 32'(m_rd), "R3 R6 R7 rd_count");
    chk(32'(tc), 32'(m_tc), "R2 R5 R10 tc");
    chk(32'(busy), 32'(m_busy), "R5 R7 busy");
    chk(32'(beat_ready), 32'(m_busy), "R6 beat_ready");
    chk(32'(done), 32'(m_done), "R7 R8 done");
    chk(32'(xfer_len), 32'(m_len), "R4 xfer_len");
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    lockstep();
  endtask

  task automatic idle();
    wr_en = 0; cmd_valid = 0; cmd_dma = 0; start = 0; beat_valid = 0;
    cmd_phase = 0;
  endtask

  task automatic wbyte(input logic [1:0] s, input logic [7:0] d);
    idle(); wr_en = 1; wr_sel = s; wr_data = d; step(); idle();
  endtask

  task automatic cmd(input logic dmaf);
    idle(); cmd_valid = 1; cmd_dma = dmaf; step(); idle();
  endtask

  task automatic go(input logic [16:0] p, input logic cph);
    idle(); start = 1; pending = p; cmd_phase = cph; step(); idle();
  endtask

  task automatic drain();
    idle(); beat_valid = 1;
    while (busy) step();
    idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(32'(rd_count), {8'd0, CHIP_ID, 16'h0}, "R9 reset count");
    chk(32'(tc), 0, "R9 reset tc");
    chk(32'(busy), 0, "R9 reset busy");

    // R1 R11: staging writes alone do not touch rd_count; sel 3 is dropped.
    wbyte(2'd0, 8'h05); wbyte(2'd1, 8'h00); wbyte(2'd2, 8'h00);
    wbyte(2'd3, 8'hFF);
    chk(32'(rd_count), {8'd0, CHIP_ID, 16'h0}, "R1 write leaves rd_count");
    cmd(1'b0);
    chk(32'(rd_count), {8'd0, CHIP_ID, 16'h0}, "R3 non-DMA command");
    cmd(1'b1);
    chk(32'(rd_count), 32'h000005, "R11 R3 reload value");

    // R4 R7: capped by count, then drained.
    go(17'd100, 1'b0);
    chk(32'(xfer_len), 5, "R4 count limits length");
    go(17'd2, 1'b0);
    chk(32'(xfer_len), 5, "R5 start while busy ignored");
    drain();
    chk(32'(done), 1, "R7 done pulse");
    chk(32'(tc), 1, "R7 tc set");
    chk(32'(rd_count), 0, "R7 count zeroed");
    step();
    chk(32'(done), 0, "R7 done one cycle");

    // R11: invalid select does not clear tc; R2: valid byte does.
    wbyte(2'd3, 8'h11);
    chk(32'(tc), 1, "R11 sel3 keeps tc");
    wbyte(2'd0, 8'h00);
    chk(32'(tc), 0, "R2 write clears tc");

    // R4: zero count means 65536.
    cmd(1'b1);
    go(17'd70000, 1'b0);
    chk(32'(xfer_len), 32'h10000, "R4 zero means 65536");
    drain();

    // R4: command phase caps at 32.
    wbyte(2'd0, 8'h40); cmd(1'b1);
    go(17'd1000, 1'b1);
    chk(32'(xfer_len), 32, "R4 command phase cap");
    drain();

    // R8: zero-length start completes immediately.
    wbyte(2'd0, 8'h09); cmd(1'b1);
    go(17'd0, 1'b0);
    chk(32'(done), 1, "R8 zero length done");
    chk(32'(busy), 0, "R8 busy stays low");
    chk(32'(tc), 1, "R8 tc set");

    // R10: final beat together with a byte write.
    wbyte(2'd0, 8'h02); cmd(1'b1);
    go(17'd50, 1'b0);
    idle(); beat_valid = 1; step();
    wr_en = 1; wr_sel = 2'd1; wr_data = 8'h07; step(); idle();
    chk(32'(tc), 1, "R10 completion beats write");

    // R10: final beat together with a DMA reload.
    wbyte(2'd1, 8'h00); cmd(1'b1);
    go(17'd1, 1'b0);
    idle(); beat_valid = 1; cmd_valid = 1; cmd_dma = 1; step(); idle();
    chk(32'(rd_count), 0, "R10 completion beats reload");

    // Random phase.
    for (int n = 0; n < 4000; n++) begin
      wr_en      = ($urandom_range(0, 9) < 3);
      wr_sel     = 2'($urandom_range(0, 3));
      wr_data    = 8'($urandom);
      cmd_valid  = ($urandom_range(0, 9) < 1);
      cmd_dma    = 1'($urandom);
      start      = ($urandom_range(0, 9) < 2);
      pending    = 17'($urandom_range(0, 40));
      cmd_phase  = ($urandom_range(0, 7) == 0);
      beat_valid = ($urandom_range(0, 9) < 7);
      step();
    end
    idle();
    step();
    finish_run();
  end
endmodule